// File: doc/BRIEF.md
# Interrupt Bid Arbiter for Serial Channels and Timers

This block decides which interrupt source in a multi-channel serial controller the host should service next. Each channel has four sources: the receiver, the transmitter, a received-break change and an input change of state. Two counter/timers add one source each. An enabled source with a pending request places a bid word. The word is a priority value followed by the source's fixed channel number and its fixed type code. For the receiver and the transmitter, the upper bits of the value are the FIFO fill level or the free-slot count, so fuller queues bid higher. Only bids whose value is strictly above a programmable threshold take part. The largest of those wins.

The interrupt request line follows the presence of any qualifying bid in the same cycle. On an acknowledge pulse or an update command, the winner's channel, type and a byte count are captured into a current-interrupt register. That register then holds still until the next capture. A vector is built from the programmable vector base. Its low bits can be replaced by the captured type, the captured channel, or both.

Top module: `irq_bid_arbiter`

## Requirements
- R1: Source index s = 4*channel + k, where k=0 is the receiver, 1 the transmitter, 2 break change and 3 change of state; timer t has index 4*NCH + t and channel number t. The receiver value is {rx_level, rx_pri}, the transmitter value is {tx_free, tx_pri}, and the other sources use their full-width priority input.
- R2: A source is eligible only when its request, its src_en bit and value > thresh all hold; a value equal to thresh does not qualify, and a masked source has no effect on the winner.
- R3: irq is high in the same cycle exactly when at least one source is eligible.
- R4: The winner is the eligible bid with the largest {value, channel, type}: ties on value go to the higher channel, then to the higher type code.
- R5: At a rising clock edge with iack or upd_cmd high, the current winner is captured; with no eligible source, cir_valid becomes 0 and the channel, type and count become 0.
- R6: Between captures, cir_valid, cir_chan, cir_type and cir_cnt do not change, whatever the inputs do.
- R7: The captured count is the rx_level of the winning channel for types 3'b011 and 3'b111, its tx_free for type 3'b010, and 0 for every other type.
- R8: vec_mode 0 gives vec_base. Mode 1 replaces vec[2:0] with cir_type. Mode 2 replaces the low CH_W bits with cir_chan. Mode 3 replaces the low 3+CH_W bits with {cir_type, cir_chan}. Bits above those always come from vec_base.
- R9: After reset, cir_valid, cir_chan, cir_type and cir_cnt are all 0.
- R10: Type codes: 3'b111 receiver with error (rx_err high), 3'b011 receiver without error, 3'b010 transmitter, 3'b001 break change, 3'b000 change of state, 3'b100 counter/timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_en | input | 4*NCH+NCT | Per-source enable, indexed as in R1 |
| rx_req | input | NCH | Receiver request per channel |
| rx_err | input | NCH | Receiver has an errored character per channel |
| tx_req | input | NCH | Transmitter request per channel |
| brk_req | input | NCH | Break change request per channel |
| cos_req | input | NCH | Input change-of-state request per channel |
| ct_req | input | NCT | Counter/timer request |
| rx_level | input | NCH*LVL_W | Receive FIFO fill per channel |
| tx_free | input | NCH*LVL_W | Transmit FIFO free slots per channel |
| rx_pri | input | NCH*(VAL_W-LVL_W) | Low receiver priority bits per channel |
| tx_pri | input | NCH*(VAL_W-LVL_W) | Low transmitter priority bits per channel |
| brk_pri | input | NCH*VAL_W | Break change priority per channel |
| cos_pri | input | NCH*VAL_W | Change-of-state priority per channel |
| ct_pri | input | NCT*VAL_W | Counter/timer priority |
| thresh | input | VAL_W | Bid threshold |
| iack | input | 1 | Interrupt acknowledge, captures the winner |
| upd_cmd | input | 1 | Update command, captures the winner |
| vec_base | input | VEC_W | Programmable vector base |
| vec_mode | input | 2 | Vector substitution mode |
| irq | output | 1 | Interrupt request |
| cir_valid | output | 1 | Captured register holds a winner |
| cir_chan | output | CH_W | Captured channel number |
| cir_type | output | 3 | Captured type code |
| cir_cnt | output | LVL_W | Captured byte count |
| vec | output | VEC_W | Interrupt vector |

## Verification
The assertions assume that iack and upd_cmd are synchronous to clk. They also assume that the request, level and priority inputs are settled around each rising edge, so the winner seen at the capture edge is the one the combinational search produced. The bench changes every input only on the falling edge and holds it through the next rising edge. Each capture pulse lasts exactly one cycle. The levels are kept within their declared width.

// File: rtl/irq_bid_pkg.sv
package irq_bid_pkg;
   localparam int TYPE_W       = 3;
   localparam int SRC_PER_CH   = 4;
   localparam int MODE_W       = 2;

   localparam logic [TYPE_W-1:0] T_COS    = 3'b000;
   localparam logic [TYPE_W-1:0] T_BRK    = 3'b001;
   localparam logic [TYPE_W-1:0] T_TX     = 3'b010;
   localparam logic [TYPE_W-1:0] T_RX_OK  = 3'b011;
   localparam logic [TYPE_W-1:0] T_TIMER  = 3'b100;
   localparam logic [TYPE_W-1:0] T_RX_ERR = 3'b111;

   typedef enum logic [MODE_W-1:0] {
      VM_BASE = 2'd0,
      VM_TYPE = 2'd1,
      VM_CHAN = 2'd2,
      VM_BOTH = 2'd3
   } vec_mode_e;

   typedef enum int {
      K_RX  = 0,
      K_TX  = 1,
      K_BRK = 2,
      K_COS = 3
   } src_kind_e;
endpackage

// File: rtl/bid_source.sv
module bid_source #(
   parameter int VAL_W  = 6,
   parameter int CH_W   = 2,
   parameter int CHAN   = 0,
   localparam int BID_W = VAL_W + CH_W + irq_bid_pkg::TYPE_W
) (
   input  logic                            req,
   input  logic                            en,
   input  logic [VAL_W-1:0]                value,
   input  logic [irq_bid_pkg::TYPE_W-1:0]  itype,
   input  logic [VAL_W-1:0]                thresh,
   output logic                            elig,
   output logic [BID_W-1:0]                bid
);
   localparam logic [CH_W-1:0] CH_ID = CH_W'(CHAN);

   if (CHAN >= (1 << CH_W)) begin : g_bad_chan
      $error("bid_source: channel number does not fit the channel field");
   end

   assign elig = req & en & (value > thresh);
   assign bid  = {value, CH_ID, itype};
endmodule

// File: rtl/bid_arbiter.sv
module bid_arbiter #(
   parameter int NSRC  = 18,
   parameter int BID_W = 11
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [NSRC-1:0]         elig,
   input  logic [NSRC*BID_W-1:0]   bids,
   output logic                    win_valid,
   output logic [BID_W-1:0]        win_bid
);
   if (NSRC < 1) begin : g_bad_nsrc
      $error("bid_arbiter: at least one source is required");
   end

   always_comb begin
      win_valid = 1'b0;
      win_bid   = '0;
      for (int i = 0; i < NSRC; i++) begin
         if (elig[i] && (!win_valid || bids[i*BID_W +: BID_W] > win_bid)) begin
            win_valid = 1'b1;
            win_bid   = bids[i*BID_W +: BID_W];
         end
      end
   end

   for (genvar g = 0; g < NSRC; g++) begin : g_chk
      AST_WIN_IS_MAX: assert property (@(posedge clk) disable iff (!rst_n)
         elig[g] |-> (win_valid && bids[g*BID_W +: BID_W] <= win_bid)); // R4
   end
endmodule

// File: rtl/cir_latch.sv
module cir_latch #(
   parameter int NCH   = 4,
   parameter int CH_W  = 2,
   parameter int LVL_W = 3
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            capture,
   input  logic                            win_valid,
   input  logic [CH_W-1:0]                 win_chan,
   input  logic [irq_bid_pkg::TYPE_W-1:0]  win_type,
   input  logic [NCH*LVL_W-1:0]            rx_level,
   input  logic [NCH*LVL_W-1:0]            tx_free,
   output logic                            cir_valid,
   output logic [CH_W-1:0]                 cir_chan,
   output logic [irq_bid_pkg::TYPE_W-1:0]  cir_type,
   output logic [LVL_W-1:0]                cir_cnt
);
   logic [LVL_W-1:0] sel_rx, sel_tx, cnt_d;

   always_comb begin
      sel_rx = '0;
      sel_tx = '0;
      for (int c = 0; c < NCH; c++) begin
         if (win_chan == CH_W'(c)) begin
            sel_rx = rx_level[c*LVL_W +: LVL_W];
            sel_tx = tx_free[c*LVL_W +: LVL_W];
         end
      end
      if (!win_valid || !win_type[1]) cnt_d = '0;
      else if (win_type[0])           cnt_d = sel_rx;
      else                            cnt_d = sel_tx;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cir_valid <= 1'b0;
         cir_chan  <= '0;
         cir_type  <= '0;
         cir_cnt   <= '0;
      end else if (capture) begin
         cir_valid <= win_valid;
         cir_chan  <= win_valid ? win_chan : '0;
         cir_type  <= win_valid ? win_type : '0;
         cir_cnt   <= cnt_d;
      end
   end

   AST_CIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !capture |=> ($stable(cir_valid) && $stable(cir_chan)
                    && $stable(cir_type) && $stable(cir_cnt))); // R6
   AST_CNT_NONE: assert property (@(posedge clk) disable iff (!rst_n)
      !cir_type[1] |-> (cir_cnt == '0)); // R7
endmodule

// File: rtl/vec_build.sv
module vec_build #(
   parameter int VEC_W = 8,
   parameter int CH_W  = 2
) (
   input  logic [VEC_W-1:0]                base,
   input  logic [irq_bid_pkg::MODE_W-1:0]  mode,
   input  logic [irq_bid_pkg::TYPE_W-1:0]  itype,
   input  logic [CH_W-1:0]                 chan,
   output logic [VEC_W-1:0]                vec
);
   import irq_bid_pkg::*;
   localparam int LOW_W = TYPE_W + CH_W;

   if (VEC_W < LOW_W) begin : g_bad_vec
      $error("vec_build: vector narrower than type and channel fields");
   end

   always_comb begin
      vec = base;
      case (vec_mode_e'(mode))
         VM_TYPE: vec[TYPE_W-1:0] = itype;
         VM_CHAN: vec[CH_W-1:0]   = chan;
         VM_BOTH: vec[LOW_W-1:0]  = {itype, chan};
         default: vec = base;
      endcase
   end
endmodule

// File: rtl/irq_bid_arbiter.sv
module irq_bid_arbiter #(
   parameter int NCH   = 4,
   parameter int NCT   = 2,
   parameter int VAL_W = 6,
   parameter int LVL_W = 3,
   parameter int VEC_W = 8,
   localparam int PRI_W = VAL_W - LVL_W,
   localparam int NMAX  = (NCH > NCT) ? NCH : NCT,
   localparam int CH_W  = (NMAX > 1) ? $clog2(NMAX) : 1,
   localparam int NSRC  = NCH * irq_bid_pkg::SRC_PER_CH + NCT
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NSRC-1:0]        src_en,
   input  logic [NCH-1:0]         rx_req,
   input  logic [NCH-1:0]         rx_err,
   input  logic [NCH-1:0]         tx_req,
   input  logic [NCH-1:0]         brk_req,
   input  logic [NCH-1:0]         cos_req,
   input  logic [NCT-1:0]         ct_req,
   input  logic [NCH*LVL_W-1:0]   rx_level,
   input  logic [NCH*LVL_W-1:0]   tx_free,
   input  logic [NCH*PRI_W-1:0]   rx_pri,
   input  logic [NCH*PRI_W-1:0]   tx_pri,
   input  logic [NCH*VAL_W-1:0]   brk_pri,
   input  logic [NCH*VAL_W-1:0]   cos_pri,
   input  logic [NCT*VAL_W-1:0]   ct_pri,
   input  logic [VAL_W-1:0]       thresh,
   input  logic                   iack,
   input  logic                   upd_cmd,
   input  logic [VEC_W-1:0]       vec_base,
   input  logic [1:0]             vec_mode,
   output logic                   irq,
   output logic                   cir_valid,
   output logic [CH_W-1:0]        cir_chan,
   output logic [2:0]             cir_type,
   output logic [LVL_W-1:0]       cir_cnt,
   output logic [VEC_W-1:0]       vec
);
   import irq_bid_pkg::*;
   localparam int BID_W = VAL_W + CH_W + TYPE_W;

   if (PRI_W < 1) begin : g_bad_val
      $error("irq_bid_arbiter: VAL_W must exceed LVL_W");
   end
   if (NCH < 1 || NCT < 0) begin : g_bad_cnt
      $error("irq_bid_arbiter: invalid source counts");
   end

   logic [NSRC-1:0]       elig;
   logic [NSRC*BID_W-1:0] bids;
   logic                  win_valid;
   logic [BID_W-1:0]      win_bid;
   logic                  capture;

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      for (genvar k = 0; k < SRC_PER_CH; k++) begin : g_kind
         localparam int S = c * SRC_PER_CH + k;
         logic             req_k;
         logic [VAL_W-1:0] val_k;
         logic [TYPE_W-1:0] typ_k;
         if (k == K_RX) begin : g_rx
            assign req_k = rx_req[c];
            assign val_k = {rx_level[c*LVL_W +: LVL_W], rx_pri[c*PRI_W +: PRI_W]};
            assign typ_k = rx_err[c] ? T_RX_ERR : T_RX_OK;
         end else if (k == K_TX) begin : g_tx
            assign req_k = tx_req[c];
            assign val_k = {tx_free[c*LVL_W +: LVL_W], tx_pri[c*PRI_W +: PRI_W]};
            assign typ_k = T_TX;
         end else if (k == K_BRK) begin : g_brk
            assign req_k = brk_req[c];
            assign val_k = brk_pri[c*VAL_W +: VAL_W];
            assign typ_k = T_BRK;
         end else begin : g_cos
            assign req_k = cos_req[c];
            assign val_k = cos_pri[c*VAL_W +: VAL_W];
            assign typ_k = T_COS;
         end
         bid_source #(.VAL_W(VAL_W), .CH_W(CH_W), .CHAN(c)) u_src (
            .req    (req_k),
            .en     (src_en[S]),
            .value  (val_k),
            .itype  (typ_k),
            .thresh (thresh),
            .elig   (elig[S]),
            .bid    (bids[S*BID_W +: BID_W])
         );
      end
   end

   for (genvar t = 0; t < NCT; t++) begin : g_ct
      localparam int S = NCH * SRC_PER_CH + t;
      bid_source #(.VAL_W(VAL_W), .CH_W(CH_W), .CHAN(t)) u_src (
         .req    (ct_req[t]),
         .en     (src_en[S]),
         .value  (ct_pri[t*VAL_W +: VAL_W]),
         .itype  (T_TIMER),
         .thresh (thresh),
         .elig   (elig[S]),
         .bid    (bids[S*BID_W +: BID_W])
      );
   end

   bid_arbiter #(.NSRC(NSRC), .BID_W(BID_W)) u_arb (
      .clk       (clk),
      .rst_n     (rst_n),
      .elig      (elig),
      .bids      (bids),
      .win_valid (win_valid),
      .win_bid   (win_bid)
   );

   assign irq     = |elig;
   assign capture = iack | upd_cmd;

   cir_latch #(.NCH(NCH), .CH_W(CH_W), .LVL_W(LVL_W)) u_cir (
      .clk       (clk),
      .rst_n     (rst_n),
      .capture   (capture),
      .win_valid (win_valid),
      .win_chan  (win_bid[TYPE_W +: CH_W]),
      .win_type  (win_bid[TYPE_W-1:0]),
      .rx_level  (rx_level),
      .tx_free   (tx_free),
      .cir_valid (cir_valid),
      .cir_chan  (cir_chan),
      .cir_type  (cir_type),
      .cir_cnt   (cir_cnt)
   );

   vec_build #(.VEC_W(VEC_W), .CH_W(CH_W)) u_vec (
      .base  (vec_base),
      .mode  (vec_mode),
      .itype (cir_type),
      .chan  (cir_chan),
      .vec   (vec)
   );

   AST_IRQ_WIN: assert property (@(posedge clk) disable iff (!rst_n)
      irq == win_valid); // R3
   AST_WIN_ABOVE_THR: assert property (@(posedge clk) disable iff (!rst_n)
      win_valid |-> (win_bid[BID_W-1 -: VAL_W] > thresh)); // R2
   AST_CAP_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      capture |=> (cir_valid == $past(irq))); // R5
   AST_VEC_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
      vec[VEC_W-1:TYPE_W+CH_W] == vec_base[VEC_W-1:TYPE_W+CH_W]); // R8
endmodule

// File: tb/irq_bid_arbiter_bench.sv
module irq_bid_arbiter_bench;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic [17:0] src_en;
   logic [3:0]  rx_req, rx_err, tx_req, brk_req, cos_req;
   logic [1:0]  ct_req;
   logic [11:0] rx_level, tx_free, rx_pri, tx_pri;
   logic [23:0] brk_pri, cos_pri;
   logic [11:0] ct_pri;
   logic [5:0]  thresh;
   logic        iack, upd_cmd;
   logic [7:0]  vec_base;
   logic [1:0]  vec_mode;
   logic        irq, cir_valid;
   logic [1:0]  cir_chan;
   logic [2:0]  cir_type, cir_cnt;
   logic [7:0]  vec;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   irq_bid_arbiter u_irq_bid_arbiter (
      .clk(clk), .rst_n(rst_n), .src_en(src_en), .rx_req(rx_req), .rx_err(rx_err),
      .tx_req(tx_req), .brk_req(brk_req), .cos_req(cos_req), .ct_req(ct_req),
      .rx_level(rx_level), .tx_free(tx_free), .rx_pri(rx_pri), .tx_pri(tx_pri),
      .brk_pri(brk_pri), .cos_pri(cos_pri), .ct_pri(ct_pri), .thresh(thresh),
      .iack(iack), .upd_cmd(upd_cmd), .vec_base(vec_base), .vec_mode(vec_mode),
      .irq(irq), .cir_valid(cir_valid), .cir_chan(cir_chan), .cir_type(cir_type),
      .cir_cnt(cir_cnt), .vec(vec)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic clear_all();
      src_en = '1; rx_req = 0; rx_err = 0; tx_req = 0; brk_req = 0; cos_req = 0;
      ct_req = 0; rx_level = 0; tx_free = 0; rx_pri = 0; tx_pri = 0;
      brk_pri = 0; cos_pri = 0; ct_pri = 0; thresh = 0; iack = 0; upd_cmd = 0;
      vec_base = 0; vec_mode = 0;
   endtask

   // Reference search built from R1, R2, R4 and R10: returns {found, value, chan, type}
   function automatic logic [11:0] model();
      logic [10:0] best = '0;
      logic        found = 1'b0;
      for (int ch = 0; ch < 4; ch++) begin
         for (int k = 0; k < 4; k++) begin
            logic r; logic [5:0] v; logic [2:0] t; logic [10:0] b;
            case (k)
               0: begin r = rx_req[ch]; v = {rx_level[ch*3 +: 3], rx_pri[ch*3 +: 3]};
                        t = rx_err[ch] ? 3'd7 : 3'd3; end
               1: begin r = tx_req[ch]; v = {tx_free[ch*3 +: 3], tx_pri[ch*3 +: 3]}; t = 3'd2; end
               2: begin r = brk_req[ch]; v = brk_pri[ch*6 +: 6]; t = 3'd1; end
               default: begin r = cos_req[ch]; v = cos_pri[ch*6 +: 6]; t = 3'd0; end
            endcase
            b = {v, 2'(ch), t};
            if (r && src_en[ch*4+k] && v > thresh && (!found || b > best)) begin
               found = 1'b1; best = b;
            end
         end
      end
      for (int t = 0; t < 2; t++) begin
         logic [10:0] b = {ct_pri[t*6 +: 6], 2'(t), 3'd4};
         if (ct_req[t] && src_en[16+t] && ct_pri[t*6 +: 6] > thresh && (!found || b > best)) begin
            found = 1'b1; best = b;
         end
      end
      return {found, best};
   endfunction

   // Drive a one-cycle capture pulse; inputs are already set. Returns at a falling edge.
   task automatic capture(input bit use_iack);
      if (use_iack) iack = 1'b1; else upd_cmd = 1'b1;
      @(posedge clk);
      @(negedge clk);
      iack = 1'b0; upd_cmd = 1'b0;
      #1;
   endtask

   task automatic expect_cir(input string tag, input bit v, input int ch, input int ty, input int cnt);
      chk({tag, " valid"}, cir_valid, v);
      chk({tag, " chan"},  cir_chan, ch);
      chk({tag, " type"},  cir_type, ty);
      chk({tag, " count"}, cir_cnt, cnt);
   endtask

   task automatic t_reset();
      #1;
      expect_cir("R9 reset", 0, 0, 0, 0);
      chk("R3 idle irq", irq, 0);
   endtask

   task automatic t_rx_count();
      clear_all();
      rx_req[2] = 1; rx_level[6 +: 3] = 3'd5; rx_pri[6 +: 3] = 3'd2; thresh = 6'd10;
      #1 chk("R3 rx irq", irq, 1);
      capture(0);
      expect_cir("R1 R7 rx level", 1, 2, 3, 5);
      rx_err[2] = 1;
      capture(1);
      expect_cir("R10 rx error type", 1, 2, 7, 5);
   endtask

   task automatic t_tx_free();
      clear_all();
      tx_req[1] = 1; tx_free[3 +: 3] = 3'd6; tx_pri[3 +: 3] = 3'd1; rx_level[3 +: 3] = 3'd2;
      capture(0);
      expect_cir("R7 tx free", 1, 1, 2, 6);
   endtask

   task automatic t_threshold();
      clear_all();
      brk_req[3] = 1; brk_pri[18 +: 6] = 6'd20; thresh = 6'd20;
      #1 chk("R2 equal threshold irq", irq, 0);
      capture(0);
      expect_cir("R5 no winner", 0, 0, 0, 0);
      thresh = 6'd19;
      #1 chk("R2 above threshold irq", irq, 1);
      capture(0);
      expect_cir("R2 break wins", 1, 3, 1, 0);
   endtask

   task automatic t_ties();
      clear_all();
      cos_req[0] = 1; cos_req[3] = 1; cos_pri[0 +: 6] = 6'd30; cos_pri[18 +: 6] = 6'd30;
      capture(0);
      expect_cir("R4 higher channel", 1, 3, 0, 0);
      clear_all();
      brk_req[1] = 1; cos_req[1] = 1; brk_pri[6 +: 6] = 6'd30; cos_pri[6 +: 6] = 6'd30;
      capture(0);
      expect_cir("R4 higher type", 1, 1, 1, 0);
      clear_all();
      ct_req[1] = 1; ct_pri[6 +: 6] = 6'd40; cos_req[1] = 1; cos_pri[6 +: 6] = 6'd40;
      capture(1);
      expect_cir("R4 R7 timer wins", 1, 1, 4, 0);
   endtask

   task automatic t_mask();
      clear_all();
      rx_req[0] = 1; rx_level[0 +: 3] = 3'd7; rx_pri[0 +: 3] = 3'd7;
      cos_req[2] = 1; cos_pri[12 +: 6] = 6'd5;
      src_en[0] = 0;
      capture(0);
      expect_cir("R2 masked source ignored", 1, 2, 0, 0);
      src_en = '0;
      #1 chk("R2 all masked irq", irq, 0);
   endtask

   task automatic t_freeze();
      clear_all();
      tx_req[0] = 1; tx_free[0 +: 3] = 3'd3;
      capture(0);
      expect_cir("R5 first capture", 1, 0, 2, 3);
      clear_all();
      rx_req[3] = 1; rx_level[9 +: 3] = 3'd4;
      repeat (3) @(negedge clk);
      #1;
      expect_cir("R6 held", 1, 0, 2, 3);
      capture(1);
      expect_cir("R5 iack recapture", 1, 3, 3, 4);
   endtask

   task automatic t_vector();
      clear_all();
      rx_req[1] = 1; rx_level[3 +: 3] = 3'd1;
      capture(0);
      vec_base = 8'hF0;
      vec_mode = 2'd0; #1 chk("R8 mode base", vec, 8'hF0);
      vec_mode = 2'd1; #1 chk("R8 mode type", vec, 8'hF3);
      vec_mode = 2'd2; #1 chk("R8 mode chan", vec, 8'hF1);
      vec_mode = 2'd3; #1 chk("R8 mode both", vec, 8'hED);
   endtask

   task automatic t_random();
      for (int n = 0; n < 300; n++) begin
         logic [11:0] m;
         int ety, ech, ecnt;
         @(negedge clk);
         src_en = 18'($urandom); rx_req = 4'($urandom); rx_err = 4'($urandom);
         tx_req = 4'($urandom); brk_req = 4'($urandom); cos_req = 4'($urandom);
         ct_req = 2'($urandom); rx_level = 12'($urandom); tx_free = 12'($urandom);
         rx_pri = 12'($urandom); tx_pri = 12'($urandom); brk_pri = 24'($urandom);
         cos_pri = 24'($urandom); ct_pri = 12'($urandom); thresh = 6'($urandom);
         #1;
         m = model();
         chk("R3 random irq", irq, m[11]);
         ety = m[11] ? int'(m[2:0]) : 0;
         ech = m[11] ? int'(m[4:3]) : 0;
         ecnt = 0;
         if (m[11] && m[1]) ecnt = m[0] ? int'(rx_level[ech*3 +: 3]) : int'(tx_free[ech*3 +: 3]);
         capture(n[0]);
         expect_cir("R4 random winner", m[11], ech, ety, ecnt);
      end
   endtask

   initial begin
      clear_all();
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_rx_count();
      t_tx_free();
      t_threshold();
      t_ties();
      t_mask();
      t_freeze();
      t_vector();
      t_random();
      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++; fails++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule